// File: doc/BRIEF.md
# Reset Request Funnel

This block merges every reset request of a small microcontroller into one system reset. Eight request sources feed it: power-on, a supply monitor, the external active-low reset pad, a missing-clock one-shot, a watchdog expiry, a comparator trip, a software request and an errant flash access. Any active request drives the system reset high at once, without waiting for a clock edge. The reset is released only after the requests have gone away, passed through a two-stage synchronizer and been held for a fixed number of extra clocks.

The reset pad is open-drain and wired-OR, so it is both an input and an output of this block. `pin_in` carries the pad level and `pin_pull_low` enables the pad's pull-down driver. Only power-on and supply-monitor resets pull the pad low. The comparator and supply-monitor requests each pass through their own enable input. A cause register keeps the set of sources seen during the most recent reset. When the reset ends, the block gives a one-cycle strobe and a set of default values: the watchdog enable, the watchdog clock divider, the program-counter start address and the port latch value.

Top module: `rst_funnel`

## Requirements
- R1: Any enabled request drives `sys_rst` high before the next rising clock edge, and `sys_rst` stays high while any request remains active.
- R2: A supply-monitor trip with `supmon_en` low, or a comparator trip with `cmp_en` low, causes no reset and leaves `cause_flags` unchanged.
- R3: `pin_pull_low` is high throughout a reset caused by power-on or by an enabled supply-monitor trip, and it falls in the same cycle that `sys_rst` falls. The other sources never raise it.
- R4: When the last request is removed, `sys_rst` falls on the (STRETCH+2)th rising edge after that removal. The default STRETCH is 4, which gives the 6th edge.
- R5: On the rising edge that follows the fall of `sys_rst`, `cause_flags` is loaded with the set of sources that were active during that reset. A power-on reset loads 8'h01 only. The bit map is: 0 power-on, 1 supply monitor, 2 pad, 3 missing clock, 4 watchdog, 5 comparator, 6 software, 7 flash error. The flags hold their value between resets.
- R6: When `swrst_wr` is high at a rising edge while `sys_rst` is low, a reset starts. That reset falls on the (STRETCH+3)th rising edge after the sampling edge. A `swrst_wr` pulse that arrives during a reset is dropped.
- R7: A low pad level causes a reset and sets flag bit 2, except while the block itself is pulling the pad low.
- R8: A missing-clock pulse shorter than one clock period still causes a reset and sets flag bit 3.
- R9: `exit_pulse` is high for exactly the one cycle after `sys_rst` falls. The default outputs are: `pc_init` = 0, `port_init` = all ones, `wdt_en_init` = 1 and `wdt_div_init` = 12.
- R10: `irq_tmr_off` is high exactly while `sys_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, active high |
| supmon_trip | input | 1 | Supply monitor trip |
| supmon_en | input | 1 | Enable for the supply-monitor source |
| pin_in | input | 1 | Level of the reset pad, low means reset |
| pin_pull_low | output | 1 | Enables the pad's open-drain pull-down |
| mcd_pulse | input | 1 | Missing-clock one-shot |
| wdt_expire | input | 1 | Watchdog timeout |
| cmp_trip | input | 1 | Comparator trip |
| cmp_en | input | 1 | Enable for the comparator source |
| swrst_wr | input | 1 | Write strobe that sets the self-clearing software reset bit |
| flash_err | input | 1 | Errant flash access |
| sys_rst | output | 1 | System reset, active high |
| irq_tmr_off | output | 1 | Holds interrupts and timers disabled |
| exit_pulse | output | 1 | One-cycle strobe at the end of a reset |
| cause_flags | output | 8 | Sources of the last reset |
| wdt_en_init | output | 1 | Watchdog enable default |
| wdt_div_init | output | 4 | Watchdog clock divider default |
| pc_init | output | 16 | Program counter start address |
| port_init | output | 8 | Port latch default |

## Verification
Two events can fall in the same cycle: several requests arriving together, and a new request arriving while a reset is already in progress. The bench raises several sources on the same edge, both in directed cases and in random cases, and expects the flag register to hold their union. A power-on request overrides the others and must leave only bit 0 set. A software write made during a watchdog reset must be dropped, so the flags must show only the watchdog. The bench also checks the release edge against the timing in R4 for every case.

// File: rtl/rst_funnel.sv
module rst_funnel #(
  parameter int STRETCH = 4,
  parameter int PC_W    = 16,
  parameter int PORT_W  = 8,
  parameter int WDT_DIV = 12,
  parameter int DIV_W   = 4
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              supmon_trip,
  input  logic              supmon_en,
  input  logic              pin_in,
  output logic              pin_pull_low,
  input  logic              mcd_pulse,
  input  logic              wdt_expire,
  input  logic              cmp_trip,
  input  logic              cmp_en,
  input  logic              swrst_wr,
  input  logic              flash_err,
  output logic              sys_rst,
  output logic              irq_tmr_off,
  output logic              exit_pulse,
  output logic [7:0]        cause_flags,
  output logic              wdt_en_init,
  output logic [DIV_W-1:0]  wdt_div_init,
  output logic [PC_W-1:0]   pc_init,
  output logic [PORT_W-1:0] port_init
);
  localparam int NSRC = 8;
  localparam int CW   = $clog2(STRETCH + 1);

  logic            sw_bit, drv, s1, s2, rst_d, raw, pin_src;
  logic [CW-1:0]   cnt;
  logic [NSRC-1:0] req, pend;

  assign pin_src = por_req | (supmon_trip & supmon_en);
  assign req = {flash_err, sw_bit, cmp_trip & cmp_en, wdt_expire, mcd_pulse,
                ~pin_in & ~drv, supmon_trip & supmon_en, por_req};
  assign raw = |req;

  always_ff @(posedge clk or posedge raw) begin
    if (raw) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      cnt   <= CW'(STRETCH);
      rst_d <= 1'b1;
    end else begin
      s1    <= 1'b0;
      s2    <= s1;
      if (!s2 && cnt != '0) cnt <= cnt - CW'(1);
      rst_d <= sys_rst;
    end
  end

  assign sys_rst = s2 | (cnt != '0);

  always_ff @(posedge clk) sw_bit <= swrst_wr & ~sys_rst;

  always_ff @(posedge clk or posedge pin_src) begin
    if (pin_src)      drv <= 1'b1;
    else if (!sys_rst) drv <= 1'b0;
  end

  assign pin_pull_low = drv & sys_rst;

  for (genvar i = 0; i < NSRC; i++) begin : g_pend
    logic hit;
    always_ff @(posedge clk or posedge req[i]) begin
      if (req[i])                hit <= 1'b1;
      else if (!sys_rst && !rst_d) hit <= 1'b0;
    end
    assign pend[i] = hit;
  end

  always_ff @(posedge clk) begin
    if (rst_d && !sys_rst) cause_flags <= pend[0] ? NSRC'(1) : pend;
  end

  assign exit_pulse   = rst_d & ~sys_rst;
  assign irq_tmr_off  = sys_rst;
  assign wdt_en_init  = 1'b1;
  assign wdt_div_init = DIV_W'(WDT_DIV);
  assign pc_init      = '0;
  assign port_init    = '1;
endmodule

// File: rtl/rst_funnel_chk.sv
module rst_funnel_chk (
  input logic       clk,
  input logic       por_req,
  input logic       wdt_expire,
  input logic       flash_err,
  input logic       mcd_pulse,
  input logic       swrst_wr,
  input logic       sys_rst,
  input logic       pin_pull_low,
  input logic       exit_pulse,
  input logic [7:0] cause_flags
);
  a_r1_req_holds_rst: assert property (@(posedge clk) disable iff (por_req)
    (wdt_expire || flash_err || mcd_pulse) |-> sys_rst);

  a_r3_drive_in_rst: assert property (@(posedge clk) disable iff (por_req)
    pin_pull_low |-> sys_rst);

  a_r3_por_drives: assert property (@(posedge clk)
    por_req |-> pin_pull_low);

  a_r4_min_len: assert property (@(posedge clk) disable iff (por_req)
    $fell(sys_rst) |-> $past(sys_rst, 2));

  a_r6_sw_starts: assert property (@(posedge clk) disable iff (por_req)
    (swrst_wr && !sys_rst) |=> sys_rst);

  a_r9_flags_loaded: assert property (@(posedge clk) disable iff (por_req)
    exit_pulse |=> (cause_flags != 8'h00));
endmodule

bind rst_funnel rst_funnel_chk u_chk (
  .clk(clk), .por_req(por_req), .wdt_expire(wdt_expire), .flash_err(flash_err),
  .mcd_pulse(mcd_pulse), .swrst_wr(swrst_wr), .sys_rst(sys_rst),
  .pin_pull_low(pin_pull_low), .exit_pulse(exit_pulse), .cause_flags(cause_flags)
);

// File: tb/rst_funnel_tb.sv
module rst_funnel_tb;
  localparam int S = 4;

  logic clk = 1'b0;
  logic por_req = 1'b0, supmon_trip = 1'b0, supmon_en = 1'b0, ext_btn = 1'b0;
  logic mcd_pulse = 1'b0, wdt_expire = 1'b0, cmp_trip = 1'b0, cmp_en = 1'b0;
  logic swrst_wr = 1'b0, flash_err = 1'b0;
  logic pin_in, pin_pull_low, sys_rst, irq_tmr_off, exit_pulse, wdt_en_init;
  logic [7:0]  cause_flags, port_init;
  logic [3:0]  wdt_div_init;
  logic [15:0] pc_init;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  logic [7:0] exp_flags;

  always #5 clk = ~clk;
  assign pin_in = ~(pin_pull_low | ext_btn);

  rst_funnel #(.STRETCH(S)) u_dut (
    .clk(clk), .por_req(por_req), .supmon_trip(supmon_trip), .supmon_en(supmon_en),
    .pin_in(pin_in), .pin_pull_low(pin_pull_low), .mcd_pulse(mcd_pulse),
    .wdt_expire(wdt_expire), .cmp_trip(cmp_trip), .cmp_en(cmp_en),
    .swrst_wr(swrst_wr), .flash_err(flash_err), .sys_rst(sys_rst),
    .irq_tmr_off(irq_tmr_off), .exit_pulse(exit_pulse), .cause_flags(cause_flags),
    .wdt_en_init(wdt_en_init), .wdt_div_init(wdt_div_init), .pc_init(pc_init),
    .port_init(port_init)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_release(input int exp_n, input logic exp_drv);
    int n = 0, bad_drv = 0, bad_q = 0;
    while (sys_rst === 1'b1 && n < 100) begin
      n++;
      if (pin_pull_low !== exp_drv) bad_drv++;
      if (irq_tmr_off !== 1'b1) bad_q++;
      @(negedge clk); #1;
    end
    check(n == exp_n, "R4 release edge", n, exp_n);
    check(bad_drv == 0, "R3 pad drive during reset", bad_drv, 0);
    check(bad_q == 0 && irq_tmr_off === 1'b0, "R10 irq/timer hold", bad_q, 0);
    check(exit_pulse === 1'b1, "R9 exit strobe high", exit_pulse, 1);
    check(pin_pull_low === 1'b0, "R3 pad released", pin_pull_low, 0);
    @(negedge clk); #1;
    check(exit_pulse === 1'b0, "R9 exit strobe one cycle", exit_pulse, 0);
  endtask

  task automatic apply(input logic [7:0] m, input logic sen, input logic cen, input int hold);
    logic [7:0] eff;
    eff = m;
    eff[1] = m[1] & sen;
    eff[5] = m[5] & cen;
    repeat (2) @(negedge clk);
    supmon_en = sen; cmp_en = cen;
    supmon_trip = m[1]; ext_btn = m[2]; mcd_pulse = m[3];
    wdt_expire = m[4]; cmp_trip = m[5]; flash_err = m[7];
    #1;
    if (eff != 0) begin
      check(sys_rst === 1'b1, "R1 async assert", sys_rst, 1);
      check(pin_pull_low === eff[1], "R3 pad drive", pin_pull_low, eff[1]);
    end else begin
      check(sys_rst === 1'b0, "R2 gated trip ignored", sys_rst, 0);
    end
    repeat (hold) @(negedge clk);
    supmon_trip = 0; ext_btn = 0; mcd_pulse = 0; wdt_expire = 0; cmp_trip = 0; flash_err = 0;
    #1;
    if (eff != 0) begin
      run_release(S + 2, eff[1]);
      exp_flags = eff;
      check(cause_flags == exp_flags, "R5 cause flags", cause_flags, exp_flags);
    end else begin
      repeat (3) @(negedge clk);
      #1;
      check(sys_rst === 1'b0 && cause_flags == exp_flags, "R2 flags unchanged", cause_flags, exp_flags);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd1357));
    #1 por_req = 1'b1; wdt_expire = 1'b1;
    #1;
    check(sys_rst === 1'b1 && pin_pull_low === 1'b1, "R3 power-on drives pad", {sys_rst, pin_pull_low}, 2'b11);
    repeat (4) @(negedge clk);
    por_req = 1'b0; wdt_expire = 1'b0;
    #1;
    run_release(S + 2, 1'b1);
    exp_flags = 8'h01;
    check(cause_flags == 8'h01, "R5 power-on only bit0", cause_flags, 8'h01);
    check(pc_init == 16'h0 && port_init == 8'hFF, "R9 pc/port defaults", {pc_init, port_init}, 24'h0000FF);
    check(wdt_en_init === 1'b1 && wdt_div_init == 4'd12, "R9 watchdog defaults", {wdt_en_init, wdt_div_init}, 5'h1C);

    apply(8'h10, 0, 0, 1);
    apply(8'h80, 0, 0, 2);
    apply(8'h04, 0, 0, 2);
    check(exp_flags == 8'h04, "R7 pad flag", cause_flags, 8'h04);
    apply(8'h02, 1, 0, 3);
    check(cause_flags[2] === 1'b0, "R7 self-driven pad not flagged", cause_flags[2], 0);
    apply(8'h02, 0, 0, 2);
    apply(8'h20, 0, 0, 2);
    apply(8'h20, 0, 1, 1);
    apply(8'h18, 0, 0, 1);

    repeat (2) @(negedge clk);
    mcd_pulse = 1'b1;
    #1 check(sys_rst === 1'b1, "R8 short one-shot asserts", sys_rst, 1);
    #1 mcd_pulse = 1'b0;
    #1;
    run_release(S + 2, 1'b0);
    check(cause_flags == 8'h08, "R8 one-shot flag", cause_flags, 8'h08);

    repeat (2) @(negedge clk);
    swrst_wr = 1'b1;
    @(negedge clk);
    swrst_wr = 1'b0;
    #1;
    run_release(S + 3, 1'b0);
    check(cause_flags == 8'h40, "R6 software flag", cause_flags, 8'h40);

    repeat (2) @(negedge clk);
    wdt_expire = 1'b1; swrst_wr = 1'b1;
    @(negedge clk);
    swrst_wr = 1'b0;
    @(negedge clk);
    wdt_expire = 1'b0;
    #1;
    run_release(S + 2, 1'b0);
    check(cause_flags == 8'h10, "R6 write during reset dropped", cause_flags, 8'h10);

    for (int k = 0; k < 40; k++) begin
      logic [7:0] m;
      logic sen, cen;
      m   = 8'($urandom) & 8'hBE;
      sen = 1'($urandom);
      cen = 1'($urandom);
      if (m[1] && sen) m[2] = 1'b0;
      apply(m, sen, cen, 1 + int'($urandom % 3));
    end

    summary();
  end
endmodule